// File: doc/BRIEF.md
# Byte-Parity Integrity Error Logger

This block guards a memory's stored data with one parity bit per data byte. On the write side it produces the parity bits that are stored next to each byte. On the read side it recomputes parity for every returned word, compares the result with the stored bits, and flags any disagreement. The flag goes straight back to the bus so that the read ends with an error response.

Each detected failure is also logged. A summary error bit and an uncorrectable type bit are set, the read address is captured, and a level-sensitive interrupt is raised. A correctable type bit is present in the register layout but is never set, because parity can detect an error but cannot repair it. Software reads the small register bank through a simple select/write port. It clears the condition by writing both type bits to the type register.

Top module: `parity_err_logger`

## Requirements
- R1: For each data byte i, `wr_par_o[i]` makes the nine bits (the byte plus its parity bit) hold an odd number of ones.
- R2: `rd_err_o` is high in the same cycle as a read with `rd_valid_i` high where any byte of `rd_data_i` and its bit in `rd_par_i` together hold an even number of ones. It is low in every other cycle.
- R3: A flagged read sets the status error bit (register index 0, bit 0) and the uncorrectable bit (register index 1, bit 1) at the next clock edge.
- R4: A flagged read loads its `rd_addr_i` into the address register (index 2, low ADDR_W bits) at the next clock edge.
- R5: Reads with correct parity, and cycles with `rd_valid_i` low, change neither the address register nor the error bits.
- R6: The correctable bit (register index 1, bit 0) always reads 0.
- R7: `irq_o` is a level that equals the status error bit in every cycle.
- R8: A write to index 1 whose data bits [1:0] are 2'b11 clears the status bit and both type bits at the next edge and leaves the address unchanged. Writes with any other value, or to any other index, have no effect.
- R9: When a flagged read and a clearing write arrive in the same cycle, the error bits stay set and the address takes the new read address.
- R10: After reset, every register reads 0 and `irq_o` is low.
- R11: Readback is combinational from `reg_sel_i`. Index 3 and all unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | DATA_W | Word about to be stored |
| wr_par_o | output | DATA_W/8 | Odd parity bits for the stored word |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Word returned by the memory |
| rd_par_i | input | DATA_W/8 | Stored parity bits returned with the word |
| rd_addr_i | input | ADDR_W | Address of the read |
| rd_err_o | output | 1 | Error response for the current read |
| irq_o | output | 1 | Integrity error interrupt (level) |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register index |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register readback |

## Verification
The bench sends random words with single-bit flips in data or parity, so that every byte lane and the parity lane itself get corrupted. A design that checked even parity, or skipped a lane, would miss errors or flag clean reads. Clearing writes are mixed in at random indices and with random values. A design that decoded the clear loosely would drop errors after writes of 1 or 2, or after writes to the status index. Directed cases place a failure in the same cycle as a clear. A design that gave the clear priority would lose the error and keep a stale address. Clean reads after a failure catch a design that captures the address on every valid read.

// File: rtl/parity_log_pkg.sv
package parity_log_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_KIND   = 2'd1,
    SEL_ADDR   = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  localparam logic [1:0] KIND_CLEAR_ALL = 2'b11;

  // Odd parity: the returned bit makes byte plus bit contain an odd number of ones.
  function automatic logic odd_parity(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/byte_par_gen.sv
module byte_par_gen #(
  parameter int NBYTES = 4
) (
  input  logic [NBYTES*8-1:0] data_i,
  output logic [NBYTES-1:0]   par_o
);
  import parity_log_pkg::*;
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign par_o[g] = odd_parity(data_i[g*8 +: 8]);
  end
endmodule

// File: rtl/byte_par_check.sv
module byte_par_check #(
  parameter int NBYTES = 4
) (
  input  logic                valid_i,
  input  logic [NBYTES*8-1:0] data_i,
  input  logic [NBYTES-1:0]   par_i,
  output logic [NBYTES-1:0]   lane_bad_o,
  output logic                fail_o
);
  logic [NBYTES-1:0] recomputed;

  byte_par_gen #(.NBYTES(NBYTES)) u_regen (
    .data_i (data_i),
    .par_o  (recomputed)
  );

  assign lane_bad_o = recomputed ^ par_i;
  assign fail_o     = valid_i && (|lane_bad_o);
endmodule

// File: rtl/err_log_state.sv
module err_log_state #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fail_i,
  input  logic [ADDR_W-1:0] fail_addr_i,
  input  logic              clear_i,
  output logic              status_q_o,
  output logic              uncorr_q_o,
  output logic [ADDR_W-1:0] addr_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q_o <= 1'b0;
      uncorr_q_o <= 1'b0;
      addr_q_o   <= '0;
    end else if (fail_i) begin
      // a new failure outranks a clear in the same cycle
      status_q_o <= 1'b1;
      uncorr_q_o <= 1'b1;
      addr_q_o   <= fail_addr_i;
    end else if (clear_i) begin
      status_q_o <= 1'b0;
      uncorr_q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/parity_err_logger.sv
module parity_err_logger #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int REG_W  = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [DATA_W/8-1:0]    wr_par_o,
  input  logic                   rd_valid_i,
  input  logic [DATA_W-1:0]      rd_data_i,
  input  logic [DATA_W/8-1:0]    rd_par_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic                   rd_err_o,
  output logic                   irq_o,
  input  logic                   reg_we_i,
  input  logic [1:0]             reg_sel_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [REG_W-1:0]       reg_rdata_o
);
  import parity_log_pkg::*;

  localparam int NBYTES = DATA_W / 8;

  // named internal events, used by the bound checker
  logic              fail_evt;
  logic              clear_evt;
  logic              status_q;
  logic              uncorr_q;
  logic              corr_bit;
  logic [ADDR_W-1:0] addr_q;
  logic [NBYTES-1:0] lane_bad;
  logic              unused_wdata;

  byte_par_gen #(.NBYTES(NBYTES)) u_wgen (
    .data_i (wr_data_i),
    .par_o  (wr_par_o)
  );

  byte_par_check #(.NBYTES(NBYTES)) u_rchk (
    .valid_i    (rd_valid_i),
    .data_i     (rd_data_i),
    .par_i      (rd_par_i),
    .lane_bad_o (lane_bad),
    .fail_o     (fail_evt)
  );

  assign clear_evt    = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_KIND)
                        && (reg_wdata_i[1:0] == KIND_CLEAR_ALL);
  assign unused_wdata = ^{reg_wdata_i[REG_W-1:2], lane_bad};

  err_log_state #(.ADDR_W(ADDR_W)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fail_i      (fail_evt),
    .fail_addr_i (rd_addr_i),
    .clear_i     (clear_evt),
    .status_q_o  (status_q),
    .uncorr_q_o  (uncorr_q),
    .addr_q_o    (addr_q)
  );

  // parity only detects, so the correctable class never occurs
  assign corr_bit = 1'b0;
  assign rd_err_o = fail_evt;
  assign irq_o    = status_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_e'(reg_sel_i))
      SEL_STATUS: reg_rdata_o[0]          = status_q;
      SEL_KIND:   reg_rdata_o[1:0]        = {uncorr_q, corr_bit};
      SEL_ADDR:   reg_rdata_o[ADDR_W-1:0] = addr_q;
      default:    reg_rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/parity_err_logger_sva.sv
module parity_err_logger_sva #(
  parameter int ADDR_W = 10,
  parameter int REG_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_valid_i,
  input logic              rd_err_o,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              irq_o,
  input logic              clear_evt,
  input logic              status_q,
  input logic              uncorr_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [1:0]        reg_sel_i,
  input logic [REG_W-1:0]  reg_rdata_o
);
  p_err_needs_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> rd_valid_i);

  p_fail_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |=> (status_q && uncorr_q));

  p_addr_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |=> (addr_q == $past(rd_addr_i)));

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_err_o |=> $stable(addr_q));

  p_corr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'd1) |-> (reg_rdata_o[0] == 1'b0));

  p_irq_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == status_q);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_evt && !rd_err_o) |=> (!status_q && !uncorr_q && $stable(addr_q)));

  p_fail_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_evt && rd_err_o) |=> status_q);
endmodule

bind parity_err_logger parity_err_logger_sva #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_valid_i  (rd_valid_i),
  .rd_err_o    (rd_err_o),
  .rd_addr_i   (rd_addr_i),
  .irq_o       (irq_o),
  .clear_evt   (clear_evt),
  .status_q    (status_q),
  .uncorr_q    (uncorr_q),
  .addr_q      (addr_q),
  .reg_sel_i   (reg_sel_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/parity_err_logger_test.sv
`timescale 1ns/1ps
module parity_err_logger_test;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam int RW = 32;
  localparam int NB = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_par;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic [NB-1:0] rd_par = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_err;
  logic          irq;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  bit          m_err = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #2.5 clk = ~clk;

  parity_err_logger #(.DATA_W(DW), .ADDR_W(AW), .REG_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_data_i(wr_data), .wr_par_o(wr_par),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .rd_par_i(rd_par),
    .rd_addr_i(rd_addr), .rd_err_o(rd_err), .irq_o(irq),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata)
  );

  // bench's own parity: count ones per byte, odd total required
  function automatic logic [NB-1:0] ref_par(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += int'(d[b*8+k]);
      p[b] = (ones % 2 == 0);
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] sel, input logic [RW-1:0] exp, input string req);
    @(negedge clk);
    rd_valid = 1'b0; reg_we = 1'b0; reg_sel = sel;
    #1 check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic check_all_regs(input string req);
    read_reg(2'd0, {31'd0, m_err}, req);
    read_reg(2'd1, {30'd0, m_err, 1'b0}, req);
    read_reg(2'd2, {22'd0, m_addr}, req);
    read_reg(2'd3, '0, req);
  endtask

  // one cycle of stimulus with model update and checks
  task automatic cycle(input logic [DW-1:0] d, input logic [NB-1:0] p, input bit v,
                       input logic [AW-1:0] a, input bit we, input logic [1:0] sel,
                       input logic [RW-1:0] wd);
    bit exp_fail, exp_clr;
    logic [DW-1:0] wd_rand;
    @(negedge clk);
    wd_rand = $urandom;
    wr_data = wd_rand;
    rd_data = d; rd_par = p; rd_valid = v; rd_addr = a;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    exp_fail = v && (p != ref_par(d));
    exp_clr  = we && (sel == 2'd1) && (wd[1:0] == 2'b11);
    #1;
    check(rd_err == exp_fail, "R2 rd_err", {31'd0, rd_err}, {31'd0, exp_fail});
    check(wr_par == ref_par(wd_rand), "R1 wr_par", {28'd0, wr_par}, {28'd0, ref_par(wd_rand)});
    @(posedge clk);
    if (exp_fail) begin m_err = 1'b1; m_addr = a; end
    else if (exp_clr) m_err = 1'b0;
    #1 check(irq == m_err, "R7 irq level", {31'd0, irq}, {31'd0, m_err});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1 check(irq == 1'b0, "R10 irq after reset", {31'd0, irq}, 0);
    rst_n = 1'b1;
    check_all_regs("R10 reset regs");

    // directed: clean read leaves state at zero
    d = 32'hA5A5_0F0F;
    cycle(d, ref_par(d), 1'b1, 10'h055, 1'b0, 2'd0, 0);
    check_all_regs("R5 clean read");
    // single bad lane
    cycle(d, ref_par(d) ^ 4'b0100, 1'b1, 10'h3C1, 1'b0, 2'd0, 0);
    check_all_regs("R3 R4 R6 fail logged");
    // bad data while not valid: nothing
    cycle(d ^ 32'h1, ref_par(d), 1'b0, 10'h111, 1'b0, 2'd0, 0);
    read_reg(2'd2, {22'd0, 10'h3C1}, "R5 invalid read keeps addr");
    // non-clearing writes
    cycle(d, ref_par(d), 1'b0, 0, 1'b1, 2'd1, 32'h1);
    cycle(d, ref_par(d), 1'b0, 0, 1'b1, 2'd1, 32'h2);
    cycle(d, ref_par(d), 1'b0, 0, 1'b1, 2'd0, 32'h3);
    cycle(d, ref_par(d), 1'b0, 0, 1'b1, 2'd2, 32'h3);
    check_all_regs("R8 other writes ignored");
    // proper clear
    cycle(d, ref_par(d), 1'b0, 0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    check_all_regs("R8 clear");
    // fail and clear together
    cycle(d, ref_par(d) ^ 4'b1001, 1'b1, 10'h2AA, 1'b0, 2'd0, 0);
    cycle(d, ref_par(d) ^ 4'b0001, 1'b1, 10'h0F3, 1'b1, 2'd1, 32'h3);
    check_all_regs("R9 fail beats clear");
    cycle(d, ref_par(d), 1'b1, 10'h001, 1'b1, 2'd1, 32'h3);
    check_all_regs("R8 clear after R9");

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      logic [DW-1:0] rd;
      logic [NB-1:0] rp;
      int pos;
      rd = $urandom;
      rp = ref_par(rd);
      if ($urandom % 3 == 0) begin
        pos = $urandom % (DW + NB);
        if (pos < DW) rd[pos] = ~rd[pos];
        else rp[pos-DW] = ~rp[pos-DW];
      end
      cycle(rd, rp, ($urandom % 4) != 0, AW'($urandom), ($urandom % 5) == 0,
            2'($urandom), RW'($urandom % 4));
      if (it % 50 == 0) check_all_regs("R11 R4 random readback");
    end
    check_all_regs("R11 final readback");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule